// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. The integrator, its capacitor, the threshold and polarity comparators and the analog switches sit outside. The block only decides when each switch is closed and how many clocks pass before the integrator returns to its low threshold. A conversion has three timed phases. First the zeroing switch is closed to remove offset, so a zero input reads as zero. Next the unknown input is integrated for a fixed window. Then a reference of the opposite sign discharges the integrator at a fixed slope while a counter runs.

The result does not depend on the capacitor value, because the digital side only fixes the run-up window and counts the run-down time. The run-up window should be a whole number of mains periods. Its default is a tenth of a second of clocks, which rejects both 50 Hz and 60 Hz pickup. Both comparator inputs are asynchronous and pass through a two-stage synchronizer. The run-down count is corrected for the latency of that synchronizer.

The polarity comparator is sampled at the end of run-up. It selects which reference is used for run-down and is reported as the sign of the result. If the threshold comparator has not tripped within the allowed run-down length, the conversion ends and is marked overrange. The reset input is asynchronous and active low. It is expected to be released synchronously to the clock.

Top module: `dslope_adc_seq`

## Requirements
- R1: While reset is low, and on the first cycle after reset is released, all four switch enables, busy, done, overrange and sign are 0 and the count is 0. Asserting reset during a conversion opens every switch at once, without waiting for a clock edge.
- R2: A start request sampled high at a rising edge while busy is low makes busy and the zeroing switch high in the next cycle. A start request sampled while busy is high is ignored and is not remembered for later.
- R3: Each conversion closes the zeroing switch for AZ_CYC cycles, opens all switches for one cycle, closes the input switch for exactly RUNUP_CYC cycles, opens all switches for one cycle, and then closes one reference switch.
- R4: At most one switch enable is high in any cycle. Before any switch closes, there is a cycle in which all switches are open.
- R5: The value of cmp_pos_i at the end of run-up selects the reference. A value of 1 closes sw_refn_o and reports sign 0. A value of 0 closes sw_refp_o and reports sign 1. Changes to cmp_pos_i after run-up ends do not change the switch in use.
- R6: Suppose cmp_low_i is first sampled high on the N-th rising edge after the reference switch closes, with N-1 not above MAX_DN. Then the count is N-1 and overrange is 0, and the reference switch stays closed for N+2 cycles. If cmp_low_i is already high before run-down begins, the reference is closed for one cycle and the count is 0.
- R7: If N-1 would exceed MAX_DN, the reference switch opens after MAX_DN+3 cycles, overrange is 1 and the count saturates at MAX_DN.
- R8: In the cycle in which the reference switch opens, done is high and busy is low. In the next cycle done is low again.
- R9: Count, overrange and sign change only in a cycle in which done is high. At all other times they hold their values, including through the next conversion.
- R10: cmp_low_i has no effect outside run-down. Holding it high in idle does not start a conversion, and holding it high during run-up does not shorten run-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled at rising edges |
| cmp_low_i | input | 1 | Asynchronous comparator: integrator at or below its low threshold |
| cmp_pos_i | input | 1 | Asynchronous comparator: integrator output positive |
| sw_zero_o | output | 1 | Zeroing switch enable |
| sw_in_o | output | 1 | Input switch enable |
| sw_refp_o | output | 1 | Positive reference switch enable |
| sw_refn_o | output | 1 | Negative reference switch enable |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ovr_o | output | 1 | Last result was overrange |
| neg_o | output | 1 | Sign of last result, 1 for a negative input |
| count_o | output | RES_W | Run-down count of last result, RES_W = clog2(MAX_DN+1) |

## Verification
The bench builds the block with AZ_CYC = 5, RUNUP_CYC = 12 and MAX_DN = 20 instead of the tenth-of-a-second defaults. With these values every phase length can be counted cycle by cycle, and the overrange limit can be reached from both sides within a few dozen clocks. The comparator is driven at chosen cycles of run-down. This places counts at 0, at 1, at exactly MAX_DN, and one or more past MAX_DN with both reference polarities, so the synchronizer correction and the saturation point are each checked at their edge.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

  // Conversion phases, in the order they are visited.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ZERO  = 3'd1,
    PH_GAP_A = 3'd2,
    PH_RUNUP = 3'd3,
    PH_GAP_B = 3'd4,
    PH_RUNDN = 3'd5
  } phase_e;

  // Analog switch enables.
  typedef struct packed {
    logic zero;
    logic inp;
    logic refp;
    logic refn;
  } sw_s;

  // Switch pattern for a phase. pos_in selects the negative reference.
  function automatic sw_s sw_decode(input phase_e ph, input logic pos_in);
    sw_s s;
    s = '0;
    case (ph)
      PH_ZERO:  s.zero = 1'b1;
      PH_RUNUP: s.inp  = 1'b1;
      PH_RUNDN: begin
        s.refn = pos_in;
        s.refp = ~pos_in;
      end
      default:  s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dslope_seq_fsm.sv
module dslope_seq_fsm
  import dslope_pkg::*;
#(
  parameter int AZ_CYC    = 4,
  parameter int RUNUP_CYC = 8,
  parameter int TMR_W     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic trip_i,     // synchronized low-threshold comparator
  input  logic pos_i,      // synchronized polarity comparator
  input  logic lim_i,      // run-down counter at its limit
  output logic run_o,      // in run-down this cycle
  output logic fin_o,      // conversion ends at this edge
  output logic fin_ovr_o,  // it ends by hitting the limit
  output logic pos_q_o,    // captured polarity
  output logic busy_o,
  output sw_s  sw_o
);

  localparam logic [TMR_W-1:0] AZ_LOAD = TMR_W'(AZ_CYC - 1);
  localparam logic [TMR_W-1:0] RU_LOAD = TMR_W'(RUNUP_CYC - 1);

  phase_e           ph_q, ph_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;
  logic             pos_q, pos_d, pos_en;
  sw_s              sw_q, sw_d;
  logic             busy_q, busy_d;
  logic             tmr_zero;

  assign tmr_zero = (tmr_q == '0);

  // Next-state logic.
  always_comb begin
    ph_d      = ph_q;
    tmr_d     = tmr_q;
    tmr_en    = 1'b0;
    pos_d     = pos_q;
    pos_en    = 1'b0;
    fin_o     = 1'b0;
    fin_ovr_o = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d   = PH_ZERO;
          tmr_d  = AZ_LOAD;
          tmr_en = 1'b1;
        end
      end
      PH_ZERO: begin
        tmr_en = 1'b1;
        if (tmr_zero) ph_d  = PH_GAP_A;
        else          tmr_d = tmr_q - 1'b1;
      end
      PH_GAP_A: begin
        ph_d   = PH_RUNUP;
        tmr_d  = RU_LOAD;
        tmr_en = 1'b1;
      end
      PH_RUNUP: begin
        tmr_en = 1'b1;
        if (tmr_zero) begin
          ph_d   = PH_GAP_B;
          pos_d  = pos_i;
          pos_en = 1'b1;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      PH_GAP_B: ph_d = PH_RUNDN;
      PH_RUNDN: begin
        if (trip_i) begin
          ph_d  = PH_IDLE;
          fin_o = 1'b1;
        end else if (lim_i) begin
          ph_d      = PH_IDLE;
          fin_o     = 1'b1;
          fin_ovr_o = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
    sw_d   = sw_decode(ph_d, pos_d);
    busy_d = (ph_d != PH_IDLE);
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      sw_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      sw_q   <= sw_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= 1'b0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign run_o   = (ph_q == PH_RUNDN);
  assign pos_q_o = pos_q;
  assign busy_o  = busy_q;
  assign sw_o    = sw_q;

endmodule

// File: rtl/dslope_rundown.sv
module dslope_rundown #(
  parameter int MAX_DN   = 20,
  parameter int SYNC_LAT = 2,
  parameter int CNT_W    = 5,
  parameter int RES_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             fin_i,
  input  logic             ovr_i,
  input  logic             pos_i,
  output logic             lim_o,
  output logic             done_o,
  output logic             ovr_o,
  output logic             neg_o,
  output logic [RES_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(MAX_DN + SYNC_LAT);
  localparam logic [CNT_W-1:0] LAT     = CNT_W'(SYNC_LAT);
  localparam logic [RES_W-1:0] SAT_VAL = RES_W'(MAX_DN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RES_W-1:0] res_q, res_d, corr;
  logic             ovr_q, neg_q, done_q;

  // Cycles counted since the reference closed. Subtracting the synchronizer
  // delay gives the time to the raw comparator trip.
  always_comb begin
    cnt_d = run_i ? cnt_q + 1'b1 : '0;
    corr  = (cnt_q >= LAT) ? RES_W'(cnt_q - LAT) : '0;
    res_d = ovr_i ? SAT_VAL : corr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ovr_q <= 1'b0;
      neg_q <= 1'b0;
    end else if (fin_i) begin
      res_q <= res_d;
      ovr_q <= ovr_i;
      neg_q <= ~pos_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= fin_i;
  end

  assign lim_o   = (cnt_q == LIMIT);
  assign done_o  = done_q;
  assign ovr_o   = ovr_q;
  assign neg_o   = neg_q;
  assign count_o = res_q;

endmodule

// File: rtl/dslope_adc_seq.sv
module dslope_adc_seq
  import dslope_pkg::*;
#(
  parameter int CLK_HZ    = 10_000_000,
  parameter int AZ_CYC    = CLK_HZ / 10,
  parameter int RUNUP_CYC = CLK_HZ / 10,
  parameter int MAX_DN    = 2 * RUNUP_CYC,
  localparam int RES_W    = $clog2(MAX_DN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_low_i,
  input  logic             cmp_pos_i,
  output logic             sw_zero_o,
  output logic             sw_in_o,
  output logic             sw_refp_o,
  output logic             sw_refn_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovr_o,
  output logic             neg_o,
  output logic [RES_W-1:0] count_o
);

  localparam int SYNC_STAGES = 2;
  localparam int TMR_MAX     = (AZ_CYC > RUNUP_CYC) ? AZ_CYC : RUNUP_CYC;
  localparam int TMR_W       = $clog2(TMR_MAX + 1);
  localparam int CNT_W       = $clog2(MAX_DN + SYNC_STAGES + 1);

  logic [1:0] cmp_s;
  logic       run, fin, fin_ovr, pos_q, lim;
  sw_s        sw;

  dslope_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cmp_pos_i, cmp_low_i}),
    .q_o   (cmp_s)
  );

  dslope_seq_fsm #(
    .AZ_CYC    (AZ_CYC),
    .RUNUP_CYC (RUNUP_CYC),
    .TMR_W     (TMR_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .trip_i    (cmp_s[0]),
    .pos_i     (cmp_s[1]),
    .lim_i     (lim),
    .run_o     (run),
    .fin_o     (fin),
    .fin_ovr_o (fin_ovr),
    .pos_q_o   (pos_q),
    .busy_o    (busy_o),
    .sw_o      (sw)
  );

  dslope_rundown #(
    .MAX_DN   (MAX_DN),
    .SYNC_LAT (SYNC_STAGES),
    .CNT_W    (CNT_W),
    .RES_W    (RES_W)
  ) u_rdn (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run),
    .fin_i   (fin),
    .ovr_i   (fin_ovr),
    .pos_i   (pos_q),
    .lim_o   (lim),
    .done_o  (done_o),
    .ovr_o   (ovr_o),
    .neg_o   (neg_o),
    .count_o (count_o)
  );

  assign sw_zero_o = sw.zero;
  assign sw_in_o   = sw.inp;
  assign sw_refp_o = sw.refp;
  assign sw_refn_o = sw.refn;

endmodule

// File: rtl/dslope_adc_seq_chk.sv
module dslope_adc_seq_chk #(
  parameter int AZ_CYC    = 4,
  parameter int RUNUP_CYC = 8,
  parameter int MAX_DN    = 20,
  parameter int RES_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             sw_zero_o,
  input logic             sw_in_o,
  input logic             sw_refp_o,
  input logic             sw_refn_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             ovr_o,
  input logic             neg_o,
  input logic [RES_W-1:0] count_o
);

  logic [3:0] sws;
  int         in_len, zero_len;

  assign sws = {sw_zero_o, sw_in_o, sw_refp_o, sw_refn_o};

  // Run lengths of the zeroing and input windows, counted here so that
  // large phase parameters need no deep $past.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_len   <= 0;
      zero_len <= 0;
    end else begin
      in_len   <= sw_in_o   ? in_len + 1   : 0;
      zero_len <= sw_zero_o ? zero_len + 1 : 0;
    end
  end

  a_r4_one_switch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sws));

  a_r4_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
    (sws != 4'b0 && sws != $past(sws)) |-> ($past(sws) == 4'b0));

  a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && sw_zero_o));

  a_r3_gap_before_input: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_in_o) |-> ($past(sws) == 4'b0 && $past(sw_zero_o, 2)));

  a_r3_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_zero_o) |-> (zero_len == AZ_CYC));

  a_r3_runup_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_in_o) |-> (in_len == RUNUP_CYC));

  a_r5_sign_matches_ref: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (neg_o == $past(sw_refp_o)));

  a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (count_o <= RES_W'(MAX_DN)));

  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ovr_o) |-> (count_o == RES_W'(MAX_DN)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o) && sws == 4'b0));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable({count_o, ovr_o, neg_o}));

endmodule

bind dslope_adc_seq dslope_adc_seq_chk #(
  .AZ_CYC    (AZ_CYC),
  .RUNUP_CYC (RUNUP_CYC),
  .MAX_DN    (MAX_DN),
  .RES_W     (RES_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .sw_zero_o (sw_zero_o),
  .sw_in_o   (sw_in_o),
  .sw_refp_o (sw_refp_o),
  .sw_refn_o (sw_refn_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .ovr_o     (ovr_o),
  .neg_o     (neg_o),
  .count_o   (count_o)
);

// File: tb/dslope_adc_seq_test.sv
`timescale 1ns/1ps
module dslope_adc_seq_test;

  localparam int AZ = 5;
  localparam int RU = 12;
  localparam int MX = 20;
  localparam int RW = $clog2(MX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic low = 1'b0;
  logic pos = 1'b0;
  logic zero, inp, refp, refn, busy, done, ovr, neg;
  logic [RW-1:0] count;

  always #5 clk = ~clk;

  dslope_adc_seq #(.AZ_CYC(AZ), .RUNUP_CYC(RU), .MAX_DN(MX)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .cmp_low_i (low),
    .cmp_pos_i (pos),
    .sw_zero_o (zero),
    .sw_in_o   (inp),
    .sw_refp_o (refp),
    .sw_refn_o (refn),
    .busy_o    (busy),
    .done_o    (done),
    .ovr_o     (ovr),
    .neg_o     (neg),
    .count_o   (count)
  );

  wire [3:0] sws = {zero, inp, refp, refn};

  int total = 0;
  int fails = 0;
  int prev_cnt = 0;
  bit prev_ok = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Stimulus vectors: polarity, trip cycle, expected sign, count, overrange.
  typedef struct packed {
    logic       p;
    logic [7:0] k;
    logic       e_neg;
    logic [7:0] e_cnt;
    logic       e_ovr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'd0,  1'b0, 8'd0,  1'b0},
    '{1'b1, 8'd7,  1'b0, 8'd7,  1'b0},
    '{1'b0, 8'd7,  1'b1, 8'd7,  1'b0},
    '{1'b0, 8'd1,  1'b1, 8'd1,  1'b0},
    '{1'b1, 8'd20, 1'b0, 8'd20, 1'b0},
    '{1'b0, 8'd21, 1'b1, 8'd20, 1'b1},
    '{1'b1, 8'd40, 1'b0, 8'd20, 1'b1},
    '{1'b0, 8'd13, 1'b1, 8'd13, 1'b0}
  };

  // mode 0: plain; 1: comparator held high from run-up start;
  // 2: start pulse during run-up and polarity flip during run-down.
  task automatic conv(input bit p, input int k, input int mode, input bit e_neg,
                      input int e_cnt, input bit e_ovr, input int e_len);
    int n;
    bit other_ref;
    pos = p;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && zero, "R2 start accepted", int'({busy, zero}), 3);
    n = 0;
    while (zero && n < 1000) begin n++; @(negedge clk); end
    chk(n == AZ, "R3 zeroing length", n, AZ);
    chk(sws == 4'b0, "R4 open gap after zeroing", int'(sws), 0);
    @(negedge clk);
    chk(inp, "R3 input follows gap", int'(inp), 1);
    if (mode == 1) low = 1'b1;
    n = 0;
    while (inp && n < 1000) begin
      start = (mode == 2 && n == 3);
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(n == RU, (mode == 1) ? "R10 run-up not shortened" : "R3 run-up length", n, RU);
    chk(sws == 4'b0, "R4 open gap after run-up", int'(sws), 0);
    if (prev_ok) chk(int'(count) == prev_cnt, "R9 result held", int'(count), prev_cnt);
    @(negedge clk);
    chk(p ? (refn && !refp) : (refp && !refn), "R5 reference select",
        int'(sws), p ? 1 : 2);
    n = 0;
    other_ref = 1'b0;
    while ((refp || refn) && n < 1000) begin
      if (p ? refp : refn) other_ref = 1'b1;
      if (mode != 1 && n == k) low = 1'b1;
      if (mode == 2 && n == 2) pos = ~p;
      n++;
      @(negedge clk);
    end
    chk(done && !busy, "R8 done with busy low", int'({done, busy}), 2);
    chk(n == e_len, e_ovr ? "R7 reference window" : "R6 reference window", n, e_len);
    chk(int'(count) == e_cnt, e_ovr ? "R7 saturated count" : "R6 count", int'(count), e_cnt);
    chk(ovr == e_ovr, "R7 overrange flag", int'(ovr), int'(e_ovr));
    chk(neg == e_neg, "R5 sign", int'(neg), int'(e_neg));
    if (mode == 2) chk(!other_ref, "R5 late polarity change ignored", int'(other_ref), 0);
    low = 1'b0;
    @(negedge clk);
    chk(!done, "R8 done lasts one cycle", int'(done), 0);
    if (mode == 2) chk(!busy, "R2 start during busy not queued", int'(busy), 0);
    prev_cnt = e_cnt;
    prev_ok  = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({sws, busy, done, ovr, neg} == 8'b0 && count == '0, "R1 state in reset",
        int'({sws, busy, done, ovr, neg}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({sws, busy, done, ovr, neg} == 8'b0 && count == '0, "R1 state after release",
        int'({sws, busy, done, ovr, neg}), 0);

    // R10: comparator high while idle starts nothing
    low = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && sws == 4'b0, "R10 idle comparator ignored",
        int'({busy, done, sws}), 0);
    low = 1'b0;
    repeat (3) @(negedge clk);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      conv(VEC[i].p, int'(VEC[i].k), 0, VEC[i].e_neg, int'(VEC[i].e_cnt),
           VEC[i].e_ovr, VEC[i].e_ovr ? MX + 3 : int'(VEC[i].k) + 3);
    end

    // R6/R10: comparator already tripped before run-down gives zero
    conv(1'b0, 0, 1, 1'b1, 0, 1'b0, 1);
    // R2/R5: start while busy and late polarity change
    conv(1'b1, 9, 2, 1'b0, 9, 1'b0, 12);
    repeat (3) @(negedge clk);
    chk(!busy, "R2 no queued conversion", int'(busy), 0);

    // R1: reset during run-up opens switches immediately
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (AZ + 4) @(negedge clk);
    chk(inp, "R3 in run-up before reset", int'(inp), 1);
    rst_n = 1'b0;
    #1;
    chk(sws == 4'b0 && !busy, "R1 asynchronous reset opens switches",
        int'({sws, busy}), 0);
    chk(count == '0 && !neg && !ovr, "R1 result cleared by reset",
        int'(count), 0);
    @(negedge clk);
    rst_n = 1'b1;
    prev_ok = 1'b0;
    @(negedge clk);
    conv(1'b1, 5, 0, 1'b0, 5, 1'b0, 8);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule